// File: doc/BRIEF.md
# Masked I2C Slave Address Matcher

This block is the address-phase front end of an I2C slave. It watches the SCL and SDA lines, detects START, repeated START and STOP conditions, shifts in the address byte (or, in 10-bit mode, the header byte followed by the low address byte), and compares what it received with a programmed address. A per-bit mask can turn any compared address bit into a don't-care. When the address matches, the block pulls SDA low through an open-drain enable during the ninth SCL clock. It also gives a one-cycle match pulse and the received read/write bit.

Software reaches the block through a small register port with three locations. Location 0 holds the low address byte. The same location also reaches a hidden mask register, but only while the mode field holds the mask-access code. Location 1 holds the two top address bits for 10-bit addressing, and location 2 holds the 4-bit mode field. The mask must be loaded before a slave mode is selected. Data-byte transfer after the address phase is handled elsewhere.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the mask register reads 8'hFF, the address registers read 0, the mode field reads 0, `sda_oe_o` is 0 and `addr_match_o` is 0.
- R2: A write or read at location 0 (`reg_loc_i` = 2'd0) reaches the mask register only while the mode field equals 4'b1001. Otherwise it reaches the low address register, and each register keeps its value while the other is accessed. Location 1 bits 1:0 hold address bits 9:8. Location 2 bits 3:0 hold the mode field.
- R3: In mode 4'b0110 (7-bit), the first byte after a START is received MSB first. Bits 7:1 are compared with address bits 7:1, and bit 0 is the R/W bit, which is never compared. On a match, `sda_oe_o` is high through the whole high phase of the ninth SCL clock, `addr_match_o` pulses once, and `rw_o` equals the received bit 0.
- R4: A mask bit of 0 makes that address bit a don't-care, and a mask bit of 1 demands an exact match. With address bits 7:1 = 1010000 and mask bits 7:1 = 1111001, exactly the address bytes A0h, A4h, A8h and ACh (with either R/W value) are acknowledged.
- R5: After an address byte that does not match, the block does not drive SDA and gives no match pulse for any further byte until the next START.
- R6: In mode 4'b0111 (10-bit), the first byte must be 11110, then A9, then A8, then R/W. It is acknowledged when A9:A8 equal the stored top bits, and no mask bit ever affects A9:A8. The second byte is acknowledged, and `addr_match_o` pulses, only if it equals the low address under the full 8-bit mask.
- R7: Address comparison starts only after a START or repeated START (SDA falling while SCL is high). A STOP (SDA rising while SCL is high) returns the block to idle, so a byte clocked in after a STOP without a new START is not acknowledged.
- R8: In any mode other than 4'b0110 and 4'b0111, including the mask-access code 4'b1001, the block never drives SDA and never pulses `addr_match_o`.
- R9: `addr_match_o` is never high for two cycles in a row. `sda_oe_o` only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line (asynchronous) |
| sda_i | input | 1 | I2C data line as seen on the bus (asynchronous) |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_match_o | output | 1 | One-cycle pulse when the full address has matched |
| rw_o | output | 1 | R/W bit of the last received first byte |
| reg_we_i | input | 1 | Register write strobe |
| reg_loc_i | input | 2 | Register location: 0 address/mask, 1 address bits 9:8, 2 mode |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_loc_i` |

## Verification
The bound checker watches four rules on every clock. The match strobe never lasts two cycles. SDA is never driven except in a slave mode. The open-drain enable only rises while SCL is low. A write outside mask-access mode never touches the mask, and a mask write never touches the address. Which byte values are acknowledged, how the mask and the fixed top bits act in 10-bit mode, and the silence after a mismatch or a STOP can only be shown by the bench. It runs whole bus transactions: an exhaustive sweep of the 7-bit mask example, directed 10-bit cases and random address/mask/mode mixes, each scored against expected values computed in the bench.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned LOC_W  = 2;
  localparam int unsigned HI_W   = 2;

  localparam logic [MODE_W-1:0] MODE_SLV7  = 4'b0110;
  localparam logic [MODE_W-1:0] MODE_SLV10 = 4'b0111;
  localparam logic [MODE_W-1:0] MODE_MSK   = 4'b1001;

  localparam logic [LOC_W-1:0] LOC_ADDR = 2'd0;
  localparam logic [LOC_W-1:0] LOC_HI   = 2'd1;
  localparam logic [LOC_W-1:0] LOC_MODE = 2'd2;

  localparam logic [4:0] HDR10_TAG = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK_WAIT,
    ST_ACK,
    ST_IGNORE
  } am_state_e;
endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // STAGES flops synchronise, one extra flop keeps the previous level
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_sr, sda_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[DEPTH-2:0], scl_i};
      sda_sr <= {sda_sr[DEPTH-2:0], sda_i};
    end
  end

  logic scl_now, scl_prv, sda_now, sda_prv;
  assign scl_now = scl_sr[STAGES-1];
  assign scl_prv = scl_sr[STAGES];
  assign sda_now = sda_sr[STAGES-1];
  assign sda_prv = sda_sr[STAGES];

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_prv;
  assign scl_fall_o = ~scl_now & scl_prv;
  assign start_o    = scl_now & scl_prv & sda_prv & ~sda_now;
  assign stop_o     = scl_now & scl_prv & ~sda_prv & sda_now;
endmodule

// File: rtl/i2c_am_regs.sv
module i2c_am_regs
  import i2c_am_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] addr_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [BYTE_W-1:0] mask_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [BYTE_W-1:0] addr_q, mask_q;
  logic [HI_W-1:0]   hi_q;
  logic [MODE_W-1:0] mode_q;
  logic              msk_sel;

  assign msk_sel = (mode_q == MODE_MSK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      mask_q <= '1;
      hi_q   <= '0;
      mode_q <= '0;
    end else if (we_i) begin
      unique case (loc_i)
        LOC_ADDR: begin
          if (msk_sel) mask_q <= wdata_i;
          else         addr_q <= wdata_i;
        end
        LOC_HI:   hi_q   <= wdata_i[HI_W-1:0];
        LOC_MODE: mode_q <= wdata_i[MODE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (loc_i)
      LOC_ADDR: rdata_o = msk_sel ? mask_q : addr_q;
      LOC_HI:   rdata_o[HI_W-1:0]   = hi_q;
      LOC_MODE: rdata_o[MODE_W-1:0] = mode_q;
      default: ;
    endcase
  end

  assign addr_o    = addr_q;
  assign addr_hi_o = hi_q;
  assign mask_o    = mask_q;
  assign mode_o    = mode_q;
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] mask_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  output logic              hit7_o,
  output logic              hit_hdr_o,
  output logic              hit_lo_o
);
  logic [BYTE_W-1:0] miss;

  // mask bit 1 = must match, 0 = don't care
  for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_bit
    assign miss[gi] = (rx_i[gi] ^ addr_i[gi]) & mask_i[gi];
  end

  assign hit7_o    = (miss[BYTE_W-1:1] == '0);
  assign hit_lo_o  = (miss == '0);
  // top address bits are never masked
  assign hit_hdr_o = (rx_i[BYTE_W-1:3] == HDR10_TAG) && (rx_i[2:1] == addr_hi_i);
endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
  import i2c_am_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic [BYTE_W-1:0] mask_i,
  output logic              sda_oe_o,
  output logic              match_o,
  output logic              rw_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  am_state_e         state_q;
  logic [BYTE_W-1:0] sh_q, rx_byte;
  logic [CNT_W-1:0]  cnt_q;
  logic              ten_q, second_q, last_q, match_q, rw_q;
  logic              hit7, hit_hdr, hit_lo, slave_mode;

  assign rx_byte    = {sh_q[BYTE_W-2:0], sda_i};
  assign slave_mode = (mode_i == MODE_SLV7) || (mode_i == MODE_SLV10);

  i2c_am_cmp u_cmp (
    .rx_i      (rx_byte),
    .addr_i    (addr_i),
    .mask_i    (mask_i),
    .addr_hi_i (addr_hi_i),
    .hit7_o    (hit7),
    .hit_hdr_o (hit_hdr),
    .hit_lo_o  (hit_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sh_q     <= '0;
      cnt_q    <= '0;
      ten_q    <= 1'b0;
      second_q <= 1'b0;
      last_q   <= 1'b0;
      match_q  <= 1'b0;
      rw_q     <= 1'b0;
    end else begin
      match_q <= 1'b0;
      if (start_i) begin
        state_q  <= slave_mode ? ST_SHIFT : ST_IDLE;
        cnt_q    <= '0;
        second_q <= 1'b0;
        ten_q    <= (mode_i == MODE_SLV10);
      end else if (stop_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_SHIFT: begin
            if (scl_rise_i) begin
              sh_q  <= rx_byte;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == LAST_BIT) begin
                cnt_q <= '0;
                if (!ten_q) begin
                  rw_q    <= rx_byte[0];
                  last_q  <= 1'b1;
                  match_q <= hit7;
                  state_q <= hit7 ? ST_ACK_WAIT : ST_IGNORE;
                end else if (!second_q) begin
                  rw_q    <= rx_byte[0];
                  last_q  <= 1'b0;
                  state_q <= hit_hdr ? ST_ACK_WAIT : ST_IGNORE;
                end else begin
                  last_q  <= 1'b1;
                  match_q <= hit_lo;
                  state_q <= hit_lo ? ST_ACK_WAIT : ST_IGNORE;
                end
              end
            end
          end
          ST_ACK_WAIT: if (scl_fall_i) state_q <= ST_ACK;
          ST_ACK: begin
            if (scl_fall_i) begin
              if (last_q) begin
                state_q <= ST_IGNORE;
              end else begin
                state_q  <= ST_SHIFT;
                second_q <= 1'b1;
                cnt_q    <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = (state_q == ST_ACK);
  assign match_o  = match_q;
  assign rw_o     = rw_q;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              addr_match_o,
  output logic              rw_o,
  input  logic              reg_we_i,
  input  logic [LOC_W-1:0]  reg_loc_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o
);
  logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [BYTE_W-1:0] addr_q, mask_q;
  logic [HI_W-1:0]   addr_hi_q;
  logic [MODE_W-1:0] mode_q;

  i2c_am_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_am_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .loc_i     (reg_loc_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .addr_o    (addr_q),
    .addr_hi_o (addr_hi_q),
    .mask_o    (mask_q),
    .mode_o    (mode_q)
  );

  i2c_am_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .mode_i     (mode_q),
    .addr_i     (addr_q),
    .addr_hi_i  (addr_hi_q),
    .mask_i     (mask_q),
    .sda_oe_o   (sda_oe_o),
    .match_o    (addr_match_o),
    .rw_o       (rw_o)
  );
endmodule

// File: rtl/i2c_am_checker.sv
module i2c_am_checker
  import i2c_am_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic              addr_match_o,
  input logic              reg_we_i,
  input logic [LOC_W-1:0]  reg_loc_i,
  input logic [MODE_W-1:0] mode,
  input logic [BYTE_W-1:0] mask,
  input logic [BYTE_W-1:0] addr
);
  logic msk_wr;
  assign msk_wr = reg_we_i && (reg_loc_i == LOC_ADDR) && (mode == MODE_MSK);

  AST_MATCH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_o |=> !addr_match_o); // R9

  AST_OE_RISES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i); // R9

  AST_OE_SLAVE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o || addr_match_o) |-> (mode == MODE_SLV7 || mode == MODE_SLV10)); // R8

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msk_wr |=> $stable(mask)); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msk_wr |=> $stable(addr)); // R2
endmodule

bind i2c_addr_match i2c_am_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_i        (scl_i),
  .sda_oe_o     (sda_oe_o),
  .addr_match_o (addr_match_o),
  .reg_we_i     (reg_we_i),
  .reg_loc_i    (reg_loc_i),
  .mode         (mode_q),
  .mask         (mask_q),
  .addr         (addr_q)
);

// File: tb/i2c_addr_match_test.sv
`timescale 1ns/1ps
module i2c_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_drv = 1'b1, sda_drv = 1'b1;
  logic       sda_bus;
  logic       sda_oe, match_p, rw;
  logic       reg_we = 1'b0;
  logic [1:0] reg_loc = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;

  int n_chk = 0, n_fail = 0, pulses = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_drv & ~sda_oe;

  i2c_addr_match uut (
    .clk_i (clk), .rst_ni (rst_n), .scl_i (scl_drv), .sda_i (sda_bus),
    .sda_oe_o (sda_oe), .addr_match_o (match_p), .rw_o (rw),
    .reg_we_i (reg_we), .reg_loc_i (reg_loc), .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata)
  );

  always @(negedge clk) if (match_p) pulses++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] loc, input logic [7:0] d);
    @(negedge clk);
    reg_loc = loc; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] loc, output logic [7:0] d);
    @(negedge clk);
    reg_loc = loc;
    #1 d = reg_rdata;
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wait_clk(4);
    scl_drv = 1'b1; wait_clk(8);
    sda_drv = 1'b0; wait_clk(8);
    scl_drv = 1'b0; wait_clk(4);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wait_clk(8);
    scl_drv = 1'b1; wait_clk(8);
    sda_drv = 1'b1; wait_clk(8);
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; wait_clk(8);
    scl_drv = 1'b1; wait_clk(10);
    scl_drv = 1'b0; wait_clk(2);
  endtask

  // acked = bus low through the high phase of the ninth clock
  task automatic xfer(input logic [7:0] b, output logic acked);
    logic low_a, low_b;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; wait_clk(8);
    scl_drv = 1'b1; wait_clk(1);
    low_a = ~sda_bus; wait_clk(7);
    low_b = ~sda_bus; wait_clk(1);
    scl_drv = 1'b0; wait_clk(8);
    acked = low_a & low_b;
  endtask

  function automatic logic exp7(input logic [7:0] a, input logic [7:0] m, input logic [7:0] b);
    for (int i = 1; i < 8; i++)
      if (m[i] && (a[i] != b[i])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic exp_lo(input logic [7:0] a, input logic [7:0] m, input logic [7:0] b);
    return exp7(a, m, b) && (!m[0] || a[0] == b[0]);
  endfunction

  function automatic logic exp_hdr(input logic [1:0] hi, input logic [7:0] b);
    return (b[7:3] == 5'b11110) && (b[2:1] == hi);
  endfunction

  task automatic setup(input logic [7:0] a, input logic [1:0] hi, input logic [7:0] m, input logic [3:0] md);
    reg_wr(2'd2, 8'h09);
    reg_wr(2'd0, m);
    reg_wr(2'd2, 8'h00);
    reg_wr(2'd0, a);
    reg_wr(2'd1, {6'd0, hi});
    reg_wr(2'd2, {4'd0, md});
  endtask

  task automatic run7(input string req, input logic [7:0] b, input logic exp_ack);
    logic ack;
    int p0;
    p0 = pulses;
    bus_start();
    xfer(b, ack);
    check({req, " ack"}, ack, exp_ack);
    check({req, " match pulses"}, pulses - p0, exp_ack ? 1 : 0);
    if (exp_ack && ack) check({req, " rw"}, rw, b[0]);
    bus_stop();
  endtask

  task automatic run10(input string req, input logic [7:0] h, input logic [7:0] lo,
                       input logic eh, input logic el);
    logic a1, a2;
    int p0;
    p0 = pulses;
    bus_start();
    xfer(h, a1);
    check({req, " header ack"}, a1, eh);
    if (eh && a1) check({req, " rw"}, rw, h[0]);
    xfer(lo, a2);
    check({req, " low ack"}, a2, eh && el);
    check({req, " match pulses"}, pulses - p0, (eh && el) ? 1 : 0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic ack;
    void'($urandom(32'h1c2a_5e11));
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    check("R1 sda_oe", sda_oe, 0);
    check("R1 addr_match", match_p, 0);
    reg_rd(2'd0, d); check("R1 addr reset", d, 8'h00);
    reg_rd(2'd1, d); check("R1 addr_hi reset", d, 8'h00);
    reg_rd(2'd2, d); check("R1 mode reset", d, 8'h00);
    reg_wr(2'd2, 8'h09);
    reg_rd(2'd0, d); check("R1 mask reset", d, 8'hFF);

    // R2 aliasing
    reg_wr(2'd0, 8'hF2);
    reg_rd(2'd0, d); check("R2 mask write", d, 8'hF2);
    reg_wr(2'd2, 8'h00);
    reg_rd(2'd0, d); check("R2 addr kept", d, 8'h00);
    reg_wr(2'd0, 8'hA0);
    reg_rd(2'd0, d); check("R2 addr write", d, 8'hA0);
    reg_wr(2'd2, 8'h09);
    reg_rd(2'd0, d); check("R2 mask kept", d, 8'hF2);
    reg_wr(2'd1, 8'hFE);
    reg_rd(2'd1, d); check("R2 hi field", d, 8'h02);

    // R8 mask-access mode ignores the bus
    run7("R8 mode 1001", 8'hA0, 1'b0);
    reg_wr(2'd2, 8'h00);
    run7("R8 mode 0000", 8'hA0, 1'b0);

    // R4 / R3 sweep of every 7-bit address, random R/W
    reg_wr(2'd2, 8'h06);
    for (int i = 0; i < 128; i++) begin
      logic [7:0] b;
      logic e;
      b = {i[6:0], 1'($urandom)};
      e = ({b[7:1], 1'b0} == 8'hA0) || ({b[7:1], 1'b0} == 8'hA4) ||
          ({b[7:1], 1'b0} == 8'hA8) || ({b[7:1], 1'b0} == 8'hAC);
      run7("R4 R3 example", b, e);
    end

    // R5 mismatch then matching byte without START
    bus_start();
    xfer(8'h22, ack); check("R5 mismatch ack", ack, 0);
    begin
      int p0;
      p0 = pulses;
      xfer(8'hA4, ack); check("R5 later byte ack", ack, 0);
      check("R5 later byte pulses", pulses - p0, 0);
    end
    bus_stop();

    // R7 STOP returns to idle: bits after STOP are ignored
    bus_start();
    xfer(8'hA8, ack); check("R7 ack before stop", ack, 1);
    bus_stop();
    scl_drv = 1'b0; wait_clk(4);
    xfer(8'hAC, ack); check("R7 no start ack", ack, 0);
    bus_stop();
    // repeated START restarts comparison
    bus_start();
    xfer(8'h11, ack); check("R7 first mismatch", ack, 0);
    bus_start();
    xfer(8'hA1, ack); check("R7 repeated start ack", ack, 1);
    check("R3 rw after repeated start", rw, 1);
    bus_stop();

    // R6 10-bit: all low bits masked, top bits still compared
    setup(8'h3C, 2'b10, 8'h00, 4'b0111);
    run10("R6 full mask", 8'hF4, 8'h81, 1'b1, 1'b1);
    run10("R6 hi mismatch", 8'hF2, 8'h3C, 1'b0, 1'b0);
    run10("R6 bad tag", 8'hE4, 8'h3C, 1'b0, 1'b0);
    setup(8'h5A, 2'b01, 8'hF0, 4'b0111);
    run10("R6 masked low hit", 8'hF3, 8'h53, 1'b1, 1'b1);
    run10("R6 masked low miss", 8'hF2, 8'h6A, 1'b1, 1'b0);
    setup(8'h5A, 2'b01, 8'hFF, 4'b0111);
    run10("R6 low bit0 compared", 8'hF2, 8'h5B, 1'b1, 1'b0);

    // random mix of modes, addresses and masks
    for (int t = 0; t < 40; t++) begin
      logic [7:0] a, m, b, h;
      logic [1:0] hi, hs;
      logic ten;
      a   = 8'($urandom);
      m   = 8'($urandom);
      hi  = 2'($urandom);
      ten = 1'($urandom);
      b   = ($urandom % 2) ? (a ^ (8'($urandom) & ~m)) : 8'($urandom);
      setup(a, hi, m, ten ? 4'b0111 : 4'b0110);
      if (!ten) begin
        run7("R3 R4 random 7-bit", b, exp7(a, m, b));
      end else begin
        hs = ($urandom % 4 == 0) ? 2'($urandom) : hi;
        h  = {5'b11110, hs, 1'($urandom)};
        run10("R6 random 10-bit", h, b, exp_hdr(hi, h), exp_lo(a, m, b));
      end
    end

    check("R9 sda released at end", sda_oe, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule